// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a register-programmed watchdog. Software picks one of three tick sources and a power-of-four division ratio, loads a 16-bit compare value and starts the count. Every divided tick moves a 16-bit up-counter forward by one. The step that brings the count level with the compare value raises a one-cycle reset request for the system reset logic. The same step sets a sticky expiry flag that stays set until software clears it.

A healthy system keeps the watchdog quiet by writing zero to the counter before the compare value is reached. The three tick sources are qualifying enables sampled on the single block clock. To change settings safely, software runs these steps: stop counting, write the control register with no source selected, load the compare value, zero the counter, write the control register with the chosen source, and start counting again.

Top module: `prescaled_watchdog`

## Requirements
- R1: After reset, every register reads 0 and `rst_req` and `expired` are low.
- R2: Registers sit at byte offsets 0x0 (compare, 16 bits), 0x4 (enable, bit 0 only), 0x8 (counter, 16 bits) and 0xC (control). In the control register, bits 2:0 are the source select, bits 5:3 are the divide code and bit 15 is the expiry flag. Any other bit reads 0, and an address with bits 1:0 nonzero reads 0 and writes nothing.
- R3: The counter advances only while enable bit 0 is 1. Clearing that bit freezes the count, and a counter read returns the live value.
- R4: Source select is one-hot: bit 0 takes `tick_pclk`, bit 1 takes `tick_rtc` and bit 2 takes `tick_ext`. Ticks on sources that are not selected are ignored. With no source bit set, or with more than one, the counter holds its value.
- R5: Divide codes 0 to 5 count one step per 1, 4, 16, 64, 256 and 1024 source ticks. Codes 6 and 7 act as code 5.
- R6: Any control write clears the divider, and so does a cleared enable. The first step after enable or reconfiguration therefore comes after a full divide period. With the source ticking every cycle, enable written at edge N and compare C give the request at edge N + C*divide.
- R7: When a step makes the count equal to the compare value, `rst_req` goes high for exactly one cycle, starting at the edge of that step.
- R8: `expired` (also read as control bit 15) is set together with the request and holds until a control write with bit 15 = 1. A control write with bit 15 = 0 leaves it set. If setting and clearing fall in the same cycle, setting wins.
- R9: Writing 0 to the counter clears it. Writing a nonzero value loads that value. A counter write has priority over a step in the same cycle.
- R10: The counter wraps from 0xFFFF to 0 on a step, and counting carries on from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tick_pclk | input | 1 | Source 0 tick enable |
| tick_rtc | input | 1 | Source 1 tick enable |
| tick_ext | input | 1 | Source 2 tick enable |
| rst_req | output | 1 | One-cycle reset request |
| expired | output | 1 | Sticky expiry flag |

## Verification
A divider that is off by one, or that is not cleared, moves the reset request by whole source ticks, and that shift can be as large as 1023 cycles. The scoreboard therefore predicts the exact edge of every request and flags a pulse that is early, late, duplicated or missing. A counter that steps wrongly, whether through a bad source qualification, an ignored enable or a lost write, shows up in the live counter value read within a few cycles. A flag that clears itself or cannot be cleared shows up on `expired` and on control bit 15 at the next read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // Word select taken from byte address bits 3:2
    typedef enum logic [1:0] {
        SEL_CMP  = 2'd0,
        SEL_ENA  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    localparam int SEL_LSB = 2;
endpackage

// File: rtl/wdt_src_sel.sv
module wdt_src_sel #(
    parameter int SRC_N = 3
) (
    input  logic [SRC_N-1:0] src_en,
    input  logic [SRC_N-1:0] src_ticks,
    output logic             src_valid,
    output logic             src_tick
);
    always_comb begin
        src_valid = $onehot(src_en);
        src_tick  = src_valid && (|(src_en & src_ticks));
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [CODE_W-1:0] code,
    output logic              tick_o
);
    localparam int DIV_W = 2 * MAX_CODE;

    logic [DIV_W-1:0] pre_d, pre_q;
    logic [DIV_W-1:0] term;
    int               eff;

    always_comb begin
        eff    = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        term   = DIV_W'((32'd1 << (2 * eff)) - 32'd1);
        tick_o = step && !clear && (pre_q == term);
        pre_d  = pre_q;
        if (clear) begin
            pre_d = '0;
        end else if (step) begin
            pre_d = (pre_q == term) ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/prescaled_watchdog.sv
module prescaled_watchdog
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 5,
    parameter int FLAG_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_pclk,
    input  logic              tick_rtc,
    input  logic              tick_ext,
    output logic              rst_req,
    output logic              expired
);
    localparam int SRC_N    = 3;
    localparam int CODE_LSB = SRC_N;
    localparam int CODE_MSB = SRC_N + CODE_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]  cnt;
        logic              en;
        logic [SRC_N-1:0]  src;
        logic [CODE_W-1:0] code;
        logic              flag;
        logic              pulse;
    } wdt_state_t;

    wdt_state_t st_d, st_q;

    reg_sel_e          sel;
    logic              aligned;
    logic              wr_cmp, wr_ena, wr_cnt, wr_ctrl, flag_clr;
    logic              src_valid, src_tick, pre_clear, pre_tick;
    logic [CNT_W-1:0]  inc;
    logic [CNT_W-1:0]  cnt_now, cmp_now;
    logic [SRC_N-1:0]  src_now;
    logic              en_now;

    // Address decode
    always_comb begin
        sel      = reg_sel_e'(bus_addr[SEL_LSB+1:SEL_LSB]);
        aligned  = (bus_addr[SEL_LSB-1:0] == '0);
        wr_cmp   = bus_we && aligned && (sel == SEL_CMP);
        wr_ena   = bus_we && aligned && (sel == SEL_ENA);
        wr_cnt   = bus_we && aligned && (sel == SEL_CNT);
        wr_ctrl  = bus_we && aligned && (sel == SEL_CTRL);
        flag_clr = wr_ctrl && bus_wdata[FLAG_BIT];
    end

    wdt_src_sel #(.SRC_N(SRC_N)) u_src (
        .src_en    (st_q.src),
        .src_ticks ({tick_ext, tick_rtc, tick_pclk}),
        .src_valid (src_valid),
        .src_tick  (src_tick)
    );

    assign pre_clear = wr_ctrl || !st_q.en;

    wdt_prescaler #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pre_clear),
        .step   (st_q.en && src_valid && src_tick),
        .code   (st_q.code),
        .tick_o (pre_tick)
    );

    // Next-state computation
    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        inc        = st_q.cnt + 1'b1;

        if (wr_cmp) begin
            st_d.cmp = bus_wdata[CNT_W-1:0];
        end
        if (wr_ena) begin
            st_d.en = bus_wdata[0];
        end
        if (wr_ctrl) begin
            st_d.src  = bus_wdata[SRC_N-1:0];
            st_d.code = bus_wdata[CODE_MSB:CODE_LSB];
        end
        if (flag_clr) begin
            st_d.flag = 1'b0;
        end

        if (wr_cnt) begin
            st_d.cnt = bus_wdata[CNT_W-1:0];
        end else if (pre_tick) begin
            st_d.cnt   = inc;
            st_d.pulse = (inc == st_q.cmp);
        end

        if (st_d.pulse) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_now = st_q.cnt;
    assign cmp_now = st_q.cmp;
    assign src_now = st_q.src;
    assign en_now  = st_q.en;
    assign rst_req = st_q.pulse;
    assign expired = st_q.flag;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (sel)
                SEL_CMP:  bus_rdata[CNT_W-1:0] = cmp_now;
                SEL_ENA:  bus_rdata[0] = en_now;
                SEL_CNT:  bus_rdata[CNT_W-1:0] = cnt_now;
                SEL_CTRL: begin
                    bus_rdata[SRC_N-1:0]         = src_now;
                    bus_rdata[CODE_MSB:CODE_LSB] = st_q.code;
                    bus_rdata[FLAG_BIT]          = st_q.flag;
                end
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 16,
    parameter int SRC_N = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [SRC_N-1:0] src,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             cnt_wr,
    input logic             flag_clr,
    input logic             rst_req,
    input logic             expired
);
    assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(cnt));

    assert_bad_source_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$onehot(src) && !cnt_wr) |=> $stable(cnt));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_pulse_at_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && $stable(cmp)) |-> (cnt == cmp));

    assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> expired);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !flag_clr) |=> expired);
endmodule

bind prescaled_watchdog wdt_checker #(.CNT_W(CNT_W), .SRC_N(SRC_N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_now),
    .src      (src_now),
    .cnt      (cnt_now),
    .cmp      (cmp_now),
    .cnt_wr   (wr_cnt),
    .flag_clr (flag_clr),
    .rst_req  (rst_req),
    .expired  (expired)
);

// File: tb/prescaled_watchdog_test.sv
module prescaled_watchdog_test;
    localparam logic [3:0] A_CMP = 4'h0, A_ENA = 4'h4, A_CNT = 4'h8, A_CTRL = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_pclk = 1'b0, tick_rtc = 1'b0, tick_ext = 1'b0;
    logic        rst_req, expired;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 1'b0;
    int exp_q[$];

    prescaled_watchdog uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_pclk(tick_pclk),
        .tick_rtc(tick_rtc), .tick_ext(tick_ext), .rst_req(rst_req), .expired(expired)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every observed request must match the next predicted edge
    always @(negedge clk) begin
        if (rst_n && rst_req) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R7: unexpected request at edge %0d, expected none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    mismatched++;
                    $display("FAIL R6/R7: request at edge %0d, expected %0d", cyc, e);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [15:0] e, input string tag);
        bus_addr = a;
        #1;
        compared++;
        if (bus_rdata !== e) begin
            mismatched++;
            $display("FAIL %s: addr %h read %h, expected %h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic bit_chk(input logic act, input logic e, input string tag);
        compared++;
        if (act !== e) begin
            mismatched++;
            $display("FAIL %s: got %0b, expected %0b", tag, act, e);
        end
    endtask

    // Safe reconfiguration; returns with cyc at the enable edge
    task automatic cfg(input logic [15:0] cmpv, input logic [2:0] src, input int code,
                       input bit push);
        wr(A_ENA, 16'h0);
        wr(A_CTRL, 16'(code << 3));
        wr(A_CMP, cmpv);
        wr(A_CNT, 16'h0);
        wr(A_CTRL, 16'(src) | 16'(code << 3));
        wr(A_ENA, 16'h1);
        if (push) begin
            int eff;
            eff = (code > 5) ? 5 : code;
            exp_q.push_back(cyc + int'(cmpv) * (1 << (2 * eff)));
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_and_clear();
        wr(A_ENA, 16'h0);
        wr(A_CTRL, 16'h8000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        int n, m, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(A_CMP, 16'h0, "R1");
        rd_chk(A_ENA, 16'h0, "R1");
        rd_chk(A_CNT, 16'h0, "R1");
        rd_chk(A_CTRL, 16'h0, "R1");
        bit_chk(rst_req, 1'b0, "R1 rst_req");
        bit_chk(expired, 1'b0, "R1 expired");

        // R2 register map and readback masking
        wr(A_CMP, 16'hA5C3);
        rd_chk(A_CMP, 16'hA5C3, "R2 cmp");
        wr(A_CTRL, 16'h7FED);
        rd_chk(A_CTRL, 16'h002D, "R2 ctrl");
        wr(A_ENA, 16'hFFFE);
        rd_chk(A_ENA, 16'h0, "R2 ena");
        wr(4'h9, 16'h1234);
        rd_chk(A_CNT, 16'h0, "R2 unaligned write");
        rd_chk(4'hB, 16'h0, "R2 unaligned read");
        wr(A_CTRL, 16'h0);

        // R7 divide-by-1 on source 0
        tick_pclk = 1'b1;
        cfg(16'd5, 3'b001, 0, 1'b1);
        idle(10);
        bit_chk(expired, 1'b1, "R8 set");
        wr(A_ENA, 16'h0);
        rd_chk(A_CTRL, 16'h8001, "R8 flag in ctrl");
        wr(A_CTRL, 16'h0001);
        bit_chk(expired, 1'b1, "R8 hold on bit15=0");
        wr(A_CTRL, 16'h8001);
        bit_chk(expired, 1'b0, "R8 clear");

        // R5 R6 divide ratios
        cfg(16'd3, 3'b001, 1, 1'b1); idle(16); stop_and_clear();
        cfg(16'd2, 3'b001, 2, 1'b1); idle(36); stop_and_clear();
        cfg(16'd1, 3'b001, 7, 1'b1); idle(1030); stop_and_clear();
        cfg(16'd2, 3'b001, 5, 1'b1); idle(2055); stop_and_clear();

        // R4 source 2 and source 1
        tick_pclk = 1'b0; tick_ext = 1'b1;
        cfg(16'd4, 3'b100, 0, 1'b1); idle(8); stop_and_clear();
        tick_ext = 1'b0; tick_rtc = 1'b1;
        cfg(16'd3, 3'b010, 0, 1'b1); idle(8); stop_and_clear();

        // R4 unselected ticks ignored, bad selects hold
        tick_rtc = 1'b0; tick_pclk = 1'b1; tick_ext = 1'b1;
        cfg(16'd3, 3'b010, 0, 1'b0); idle(20);
        rd_chk(A_CNT, 16'h0, "R4 unselected");
        cfg(16'd3, 3'b011, 0, 1'b0); idle(20);
        rd_chk(A_CNT, 16'h0, "R4 two sources");
        cfg(16'd3, 3'b000, 0, 1'b0); idle(20);
        rd_chk(A_CNT, 16'h0, "R4 no source");
        tick_ext = 1'b0;

        // R3 disable freezes live count
        cfg(16'h0100, 3'b001, 0, 1'b0);
        n = cyc;
        idle(7);
        wr(A_ENA, 16'h0);
        m = cyc;
        rd_chk(A_CNT, 16'(m - n), "R3 live value");
        idle(10);
        rd_chk(A_CNT, 16'(m - n), "R3 frozen");

        // R6 control write restarts divider
        cfg(16'h0100, 3'b001, 1, 1'b0);
        idle(1);
        wr(A_CTRL, 16'h0009);
        c = cyc;
        idle(3);
        rd_chk(A_CNT, 16'h0, "R6 divider cleared");
        idle(1);
        rd_chk(A_CNT, 16'h1, "R6 first step");
        stop_and_clear();

        // R9 servicing by writing zero
        cfg(16'd8, 3'b001, 0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            idle(2);
            wr(A_CNT, 16'h0);
        end
        wr(A_ENA, 16'h0);
        rd_chk(A_CNT, 16'h2, "R9 serviced count");
        bit_chk(expired, 1'b0, "R9 no expiry");

        // R9 nonzero load, R10 wrap
        cfg(16'h0040, 3'b001, 0, 1'b0);
        wr(A_CNT, 16'h003E);
        exp_q.push_back(cyc + 2);
        idle(6);
        wr(A_CMP, 16'h0001);
        wr(A_CNT, 16'hFFFF);
        exp_q.push_back(cyc + 2);
        idle(1);
        rd_chk(A_CNT, 16'h0000, "R10 wrap");
        idle(4);
        stop_and_clear();

        idle(4);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R7: %0d predicted requests missing, expected 0", exp_q.size());
        end
        if (c < 0) $display("edge %0d", c);
        finish_run();
    end
endmodule